// File: doc/BRIEF.md
# Pattern Block Sequencer

This block decides which stretch of a pattern memory is played out, and in what order. A program of sequence lines selects the order. Each line names one block from a descriptor table, which gives the block's start address and length. The line also says how many times the block repeats, with an option to repeat without end. It says whether playback must first wait for an event, what level the controlled signal takes while the line is active, and whether the sequencer continues at another line when the block finishes.

Pattern addresses leave the block as a valid/ready stream. The sequencer holds `pat_addr` and keeps `pat_valid` high until the consumer accepts the beat with `pat_ready`. Dropping `pat_ready` stalls the address stream and the repeat and jump bookkeeping, and loses no beat. Events arrive as single-cycle true indications from an external evaluator. In step mode, a manual satisfy strobe takes the place of those events.

Both tables are register arrays with a simple write port for preloading. Preloading is done while `run` is low. Every entry is read in the cycle it is needed, so one block follows another with no gap cycle.

Top module: `pgs_sequencer`

## Requirements
- R1: A sequence line is laid out from bit 0 as follows: end-of-program flag (bit 0), wait enable (bit 1), signal level (bit 2), jump mode (bits 4:3: 0 none, 1 jump when the event is true, 2 always jump, 3 none), target line (next SEQ_W bits), repeat count minus one (next 16 bits), infinite flag (next bit), block index (top BLK_W bits). A descriptor holds length minus one in its low LEN_W bits and the start address in the PA_W bits above them.
- R2: Out of reset, or one cycle after `run` is seen low, `pat_valid`, `done` and `sig_out` are low. With `run` high in idle, line 0 is loaded at the next edge.
- R3: While a block plays, `pat_addr` equals the block start plus a word offset, which starts at 0 and advances by one on each cycle with `pat_valid` and `pat_ready` both high. The address holds while `pat_ready` is low.
- R4: A line whose infinite flag is clear plays its block exactly repeat-minus-one plus one times before leaving the line.
- R5: A line with the infinite flag set replays its block until a jump is taken or `run` drops.
- R6: A line with wait enabled keeps `pat_valid` low until an event is seen. The first beat is presented in the cycle after that event.
- R7: Jump-when-event is decided in the cycle the last word of the final repetition is accepted, or of every repetition on an infinite line. An event in that cycle sends the sequencer to the target line; otherwise it goes on to the next line.
- R8: Always-jump goes to the target line whatever the event input is.
- R9: `sig_out` follows the current line's signal level while that line waits or plays, and is low otherwise.
- R10: When a line flagged end-of-program, or the highest line, finishes without a taken jump, `done` rises and `pat_valid` stays low until `run` drops.
- R11: With `step_mode` high only `step_sat` counts as an event and `evt_in` is ignored. With it low only `evt_in` counts.
- R12: Writing a line or a descriptor through its write port changes what the next run plays.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| run | input | 1 | High to run the program, low to return to idle |
| step_mode | input | 1 | Selects the manual satisfy strobe as the event source |
| step_sat | input | 1 | Manual satisfy strobe |
| evt_in | input | 1 | Event-true indication from the event evaluator |
| seq_we | input | 1 | Sequence line write enable |
| seq_waddr | input | SEQ_W | Sequence line write index |
| seq_wdata | input | LINE_W | Sequence line write data (layout per R1) |
| blk_we | input | 1 | Block descriptor write enable |
| blk_waddr | input | BLK_W | Block descriptor write index |
| blk_wdata | input | DESC_W | Block descriptor write data (layout per R1) |
| pat_valid | output | 1 | Pattern address valid |
| pat_ready | input | 1 | Consumer accepts the current address |
| pat_addr | output | PA_W | Pattern memory read address |
| sig_out | output | 1 | Controlled signal level of the current line |
| done | output | 1 | Program finished |

## Verification
The hardest point to reach is a jump decision that coincides with back-pressure, an infinite line and step mode. The event must be present in exactly the cycle the last word of a repetition is accepted, and a stalled consumer moves that cycle. The bench runs random programs with random ready, event and satisfy activity against a cycle model, so these coincidences occur often. Directed programs pin down each repeat, wait, jump and end case with event levels held fixed.

// File: rtl/pgs_pkg.sv
package pgs_pkg;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_WAIT = 2'd1,
    ST_PLAY = 2'd2,
    ST_DONE = 2'd3
  } seq_st_e;

  typedef enum logic [1:0] {
    JM_NONE   = 2'd0,
    JM_IF     = 2'd1,
    JM_ALWAYS = 2'd2,
    JM_RSVD   = 2'd3
  } jmp_e;

endpackage

// File: rtl/pgs_regfile.sv
module pgs_regfile #(
  parameter int DEPTH = 16,
  parameter int WIDTH = 8,
  localparam int AW = $clog2(DEPTH)
) (
  input  logic             clk,
  input  logic             we,
  input  logic [AW-1:0]    waddr,
  input  logic [WIDTH-1:0] wdata,
  input  logic [AW-1:0]    raddr,
  output logic [WIDTH-1:0] rdata
);

  logic [WIDTH-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
  end

  // read in the same cycle so a new line can be loaded without a gap
  assign rdata = mem[raddr];

endmodule

// File: rtl/pgs_play_ctr.sv
module pgs_play_ctr #(
  parameter int LEN_W = 8,
  parameter int RPT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic             adv,
  input  logic [LEN_W-1:0] len_m1,
  input  logic [RPT_W-1:0] rpt_m1,
  input  logic             rpt_inf,
  output logic [LEN_W-1:0] word,
  output logic             last_word,
  output logic             last_rep
);

  logic [LEN_W-1:0] word_q;
  logic [RPT_W-1:0] rep_q;

  assign word      = word_q;
  assign last_word = (word_q == len_m1);
  assign last_rep  = !rpt_inf && (rep_q == rpt_m1);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      word_q <= '0;
      rep_q  <= '0;
    end else if (load) begin
      word_q <= '0;
      rep_q  <= '0;
    end else if (adv) begin
      if (last_word) begin
        word_q <= '0;
        if (!rpt_inf && !last_rep) rep_q <= rep_q + RPT_W'(1);
      end else begin
        word_q <= word_q + LEN_W'(1);
      end
    end
  end

endmodule

// File: rtl/pgs_sequencer.sv
module pgs_sequencer
  import pgs_pkg::*;
#(
  parameter int SEQ_DEPTH = 16,
  parameter int BLK_DEPTH = 8,
  parameter int PA_W      = 12,
  parameter int LEN_W     = 8,
  parameter int RPT_W     = 16,
  localparam int SEQ_W    = $clog2(SEQ_DEPTH),
  localparam int BLK_W    = $clog2(BLK_DEPTH),
  localparam int F_LAST   = 0,
  localparam int F_WAIT   = 1,
  localparam int F_SIG    = 2,
  localparam int F_JM     = 3,
  localparam int F_TGT    = 5,
  localparam int F_RPT    = F_TGT + SEQ_W,
  localparam int F_INF    = F_RPT + RPT_W,
  localparam int F_BLK    = F_INF + 1,
  localparam int LINE_W   = F_BLK + BLK_W,
  localparam int DESC_W   = LEN_W + PA_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              run,
  input  logic              step_mode,
  input  logic              step_sat,
  input  logic              evt_in,
  input  logic              seq_we,
  input  logic [SEQ_W-1:0]  seq_waddr,
  input  logic [LINE_W-1:0] seq_wdata,
  input  logic              blk_we,
  input  logic [BLK_W-1:0]  blk_waddr,
  input  logic [DESC_W-1:0] blk_wdata,
  output logic              pat_valid,
  input  logic              pat_ready,
  output logic [PA_W-1:0]   pat_addr,
  output logic              sig_out,
  output logic              done
);

  seq_st_e           st_q;
  logic [SEQ_W-1:0]  idx_q;
  logic [SEQ_W-1:0]  rd_idx;
  logic [LINE_W-1:0] nxt_line;
  logic [DESC_W-1:0] nxt_desc;

  // fields of the line now active
  logic              cur_sig_q;
  logic              cur_last_q;
  logic              cur_inf_q;
  jmp_e              cur_jm_q;
  logic [SEQ_W-1:0]  cur_tgt_q;
  logic [RPT_W-1:0]  cur_rpt_q;
  logic [PA_W-1:0]   start_q;
  logic [LEN_W-1:0]  len_q;

  logic [LEN_W-1:0]  word;
  logic              last_word;
  logic              last_rep;

  logic evt;
  logic beat;
  logic rep_end;
  logic jmp_chk;
  logic take;
  logic line_end;
  logic final_line;
  logic enter;

  assign evt        = step_mode ? step_sat : evt_in;
  assign beat       = (st_q == ST_PLAY) && pat_ready;
  assign rep_end    = beat && last_word;
  assign jmp_chk    = rep_end && (last_rep || cur_inf_q);
  assign take       = jmp_chk &&
                      ((cur_jm_q == JM_ALWAYS) || ((cur_jm_q == JM_IF) && evt));
  assign line_end   = rep_end && last_rep && !take;
  assign final_line = cur_last_q || (idx_q == SEQ_W'(SEQ_DEPTH - 1));
  assign enter      = run && ((st_q == ST_IDLE) || take || (line_end && !final_line));

  always_comb begin
    if (st_q == ST_IDLE)  rd_idx = '0;
    else if (take)        rd_idx = cur_tgt_q;
    else                  rd_idx = idx_q + SEQ_W'(1);
  end

  pgs_regfile #(.DEPTH(SEQ_DEPTH), .WIDTH(LINE_W)) u_seq (
    .clk   (clk),
    .we    (seq_we),
    .waddr (seq_waddr),
    .wdata (seq_wdata),
    .raddr (rd_idx),
    .rdata (nxt_line)
  );

  pgs_regfile #(.DEPTH(BLK_DEPTH), .WIDTH(DESC_W)) u_blk (
    .clk   (clk),
    .we    (blk_we),
    .waddr (blk_waddr),
    .wdata (blk_wdata),
    .raddr (nxt_line[F_BLK +: BLK_W]),
    .rdata (nxt_desc)
  );

  pgs_play_ctr #(.LEN_W(LEN_W), .RPT_W(RPT_W)) u_ctr (
    .clk       (clk),
    .rst_n     (rst_n),
    .load      (enter),
    .adv       (beat),
    .len_m1    (len_q),
    .rpt_m1    (cur_rpt_q),
    .rpt_inf   (cur_inf_q),
    .word      (word),
    .last_word (last_word),
    .last_rep  (last_rep)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q       <= ST_IDLE;
      idx_q      <= '0;
      cur_sig_q  <= 1'b0;
      cur_last_q <= 1'b0;
      cur_inf_q  <= 1'b0;
      cur_jm_q   <= JM_NONE;
      cur_tgt_q  <= '0;
      cur_rpt_q  <= '0;
      start_q    <= '0;
      len_q      <= '0;
    end else if (!run) begin
      st_q <= ST_IDLE;
    end else if (enter) begin
      st_q       <= nxt_line[F_WAIT] ? ST_WAIT : ST_PLAY;
      idx_q      <= rd_idx;
      cur_sig_q  <= nxt_line[F_SIG];
      cur_last_q <= nxt_line[F_LAST];
      cur_inf_q  <= nxt_line[F_INF];
      cur_jm_q   <= jmp_e'(nxt_line[F_JM +: 2]);
      cur_tgt_q  <= nxt_line[F_TGT +: SEQ_W];
      cur_rpt_q  <= nxt_line[F_RPT +: RPT_W];
      start_q    <= nxt_desc[LEN_W +: PA_W];
      len_q      <= nxt_desc[LEN_W-1:0];
    end else if ((st_q == ST_WAIT) && evt) begin
      st_q <= ST_PLAY;
    end else if (line_end) begin
      st_q <= ST_DONE;
    end
  end

  assign pat_valid = (st_q == ST_PLAY);
  assign pat_addr  = start_q + PA_W'(word);
  assign sig_out   = ((st_q == ST_WAIT) || (st_q == ST_PLAY)) && cur_sig_q;
  assign done      = (st_q == ST_DONE);

endmodule

// File: rtl/pgs_sequencer_chk.sv
module pgs_sequencer_chk #(
  parameter int PA_W = 12
) (
  input logic            clk,
  input logic            rst_n,
  input logic            run,
  input logic            pat_valid,
  input logic            pat_ready,
  input logic [PA_W-1:0] pat_addr,
  input logic            sig_out,
  input logic            done
);

  a_r3_stall_holds: assert property (@(posedge clk) disable iff (!rst_n)
    (pat_valid && !pat_ready && run) |=> (pat_valid && $stable(pat_addr)));

  a_r2_stop_clears: assert property (@(posedge clk) disable iff (!rst_n)
    !run |=> (!pat_valid && !done && !sig_out));

  a_r10_done_silent: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (!pat_valid && !sig_out));

  a_r10_done_holds: assert property (@(posedge clk) disable iff (!rst_n)
    (done && run) |=> done);

  a_r2_one_state: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({pat_valid, done}));

endmodule

bind pgs_sequencer pgs_sequencer_chk #(.PA_W(PA_W)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .run       (run),
  .pat_valid (pat_valid),
  .pat_ready (pat_ready),
  .pat_addr  (pat_addr),
  .sig_out   (sig_out),
  .done      (done)
);

// File: tb/sim_pgs_sequencer.sv
`timescale 1ns/1ps
module sim_pgs_sequencer;

  localparam int SEQ_DEPTH = 16;
  localparam int BLK_DEPTH = 8;
  localparam int PA_W      = 12;
  localparam int LEN_W     = 8;
  localparam int RPT_W     = 16;
  localparam int SEQ_W     = $clog2(SEQ_DEPTH);
  localparam int BLK_W     = $clog2(BLK_DEPTH);
  localparam int F_TGT     = 5;
  localparam int F_RPT     = F_TGT + SEQ_W;
  localparam int F_INF     = F_RPT + RPT_W;
  localparam int F_BLK     = F_INF + 1;
  localparam int LINE_W    = F_BLK + BLK_W;
  localparam int DESC_W    = LEN_W + PA_W;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic run = 1'b0, step_mode = 1'b0, step_sat = 1'b0, evt_in = 1'b0;
  logic seq_we = 1'b0, blk_we = 1'b0;
  logic [SEQ_W-1:0]  seq_waddr = '0;
  logic [LINE_W-1:0] seq_wdata = '0;
  logic [BLK_W-1:0]  blk_waddr = '0;
  logic [DESC_W-1:0] blk_wdata = '0;
  logic pat_valid, pat_ready = 1'b1, sig_out, done;
  logic [PA_W-1:0] pat_addr;

  always #2.5 clk = ~clk;

  pgs_sequencer u0 (
    .clk(clk), .rst_n(rst_n), .run(run), .step_mode(step_mode), .step_sat(step_sat),
    .evt_in(evt_in), .seq_we(seq_we), .seq_waddr(seq_waddr), .seq_wdata(seq_wdata),
    .blk_we(blk_we), .blk_waddr(blk_waddr), .blk_wdata(blk_wdata),
    .pat_valid(pat_valid), .pat_ready(pat_ready), .pat_addr(pat_addr),
    .sig_out(sig_out), .done(done)
  );

  // bench copy of the program
  int b_blk [SEQ_DEPTH], b_rpt [SEQ_DEPTH], b_jm [SEQ_DEPTH], b_tgt [SEQ_DEPTH];
  bit b_inf [SEQ_DEPTH], b_wait [SEQ_DEPTH], b_sig [SEQ_DEPTH], b_last [SEQ_DEPTH];
  int d_start [BLK_DEPTH], d_len [BLK_DEPTH];

  int nvec = 0, nfail = 0;
  int hits [64];
  bit chk_on = 0, rnd_ready = 0, rnd_evt = 0, rnd_step = 0;

  // cycle model: 0 idle, 1 wait, 2 play, 3 done
  int m_st = 0, m_idx = 0, m_word = 0, m_rep = 0, m_start = 0, m_len = 0;
  bit m_ev, m_fin, m_tk;

  function automatic void m_enter(int i);
    m_idx   = i;
    m_start = d_start[b_blk[i]];
    m_len   = d_len[b_blk[i]];
    m_word  = 0;
    m_rep   = 0;
    m_st    = b_wait[i] ? 1 : 2;
  endfunction

  always @(posedge clk) begin
    m_ev = step_mode ? step_sat : evt_in;
    if (!rst_n) m_st = 0;
    else if (!run) m_st = 0;
    else begin
      case (m_st)
        0: m_enter(0);
        1: if (m_ev) m_st = 2;
        2: if (pat_ready) begin
          if (m_word == m_len) begin
            m_fin = !b_inf[m_idx] && (m_rep == b_rpt[m_idx]);
            m_tk  = (m_fin || b_inf[m_idx]) &&
                    (b_jm[m_idx] == 2 || (b_jm[m_idx] == 1 && m_ev));
            if (m_tk) m_enter(b_tgt[m_idx]);
            else if (!m_fin) begin
              m_word = 0;
              if (!b_inf[m_idx]) m_rep++;
            end else if (b_last[m_idx] || m_idx == SEQ_DEPTH - 1) m_st = 3;
            else m_enter(m_idx + 1);
          end else m_word++;
        end
        default: ;
      endcase
    end
  end

  function automatic bit e_valid(); return m_st == 2; endfunction
  function automatic int e_addr(); return (m_start + m_word) % (1 << PA_W); endfunction
  function automatic bit e_sig(); return (m_st == 1 || m_st == 2) && b_sig[m_idx]; endfunction
  function automatic bit e_done(); return m_st == 3; endfunction

  task automatic chk(input bit ok, input string tag, input int got, input int exp);
    nvec++;
    if (!ok) begin
      nfail++;
      $display("FAIL %s got %0d exp %0d at %0t", tag, got, exp, $time);
    end
  endtask

  task automatic tick(input int n);
    for (int i = 0; i < n; i++) begin
      @(posedge clk);
      #1;
      if (rnd_ready) pat_ready = ($urandom % 4) != 0;
      if (rnd_evt)   evt_in    = ($urandom % 4) == 0;
      if (rnd_step)  step_sat  = ($urandom % 5) == 0;
      @(negedge clk);
      if (pat_valid && pat_ready) hits[pat_addr >> 6]++;
      if (chk_on) begin
        chk(pat_valid == e_valid(), "R2 pat_valid", int'(pat_valid), int'(e_valid()));
        if (e_valid()) chk(pat_addr == PA_W'(e_addr()), "R3 pat_addr", int'(pat_addr), e_addr());
        chk(sig_out == e_sig(), "R9 sig_out", int'(sig_out), int'(e_sig()));
        chk(done == e_done(), "R10 done", int'(done), int'(e_done()));
      end
    end
  endtask

  // R1 layout
  function automatic logic [LINE_W-1:0] pack_line(int blk, int rpt, bit inf, bit wt, bit sg,
                                                  int jm, int tgt, bit last);
    logic [LINE_W-1:0] v;
    v = '0;
    v[0] = last;
    v[1] = wt;
    v[2] = sg;
    v[4:3] = 2'(jm);
    v[F_TGT +: SEQ_W] = SEQ_W'(tgt);
    v[F_RPT +: RPT_W] = RPT_W'(rpt);
    v[F_INF] = inf;
    v[F_BLK +: BLK_W] = BLK_W'(blk);
    return v;
  endfunction

  task automatic wr_line(int i, int blk, int rpt, bit inf, bit wt, bit sg, int jm, int tgt, bit last);
    b_blk[i] = blk; b_rpt[i] = rpt; b_inf[i] = inf; b_wait[i] = wt; b_sig[i] = sg;
    b_jm[i] = (jm == 3) ? 0 : jm; b_tgt[i] = tgt; b_last[i] = last;
    seq_we = 1'b1; seq_waddr = SEQ_W'(i); seq_wdata = pack_line(blk, rpt, inf, wt, sg, jm, tgt, last);
    tick(1);
    seq_we = 1'b0;
  endtask

  task automatic wr_desc(int k, int start, int len_m1);
    d_start[k] = start; d_len[k] = len_m1;
    blk_we = 1'b1; blk_waddr = BLK_W'(k);
    blk_wdata = {PA_W'(start), LEN_W'(len_m1)};
    tick(1);
    blk_we = 1'b0;
  endtask

  task automatic clear_prog();
    for (int i = 0; i < SEQ_DEPTH; i++) wr_line(i, 0, 0, 0, 0, 0, 0, 0, 0);
  endtask

  task automatic stop_run();
    run = 1'b0; evt_in = 1'b0; step_sat = 1'b0; pat_ready = 1'b1;
    tick(2);
    for (int i = 0; i < 64; i++) hits[i] = 0;
  endtask

  initial begin
    #1_000_000;
    $display("FAIL watchdog expired");
    $display("  == %0d vectors applied, %0d miscompares ==", nvec, nfail + 1);
    $finish;
  end

  initial begin
    void'($urandom(32'd5150));
    for (int i = 0; i < 64; i++) hits[i] = 0;
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    chk_on = 1;
    tick(1);
    chk(!pat_valid && !done && !sig_out, "R2 reset state", int'({pat_valid, done, sig_out}), 0);

    for (int k = 0; k < BLK_DEPTH; k++) wr_desc(k, k * 64, k % 4 + 1);

    // R4 repeats, R8 always-jump skips line 2, R10 ends on flagged line
    clear_prog();
    wr_line(0, 1, 2, 0, 0, 1, 0, 0, 0);
    wr_line(1, 2, 0, 0, 0, 0, 2, 3, 0);
    wr_line(2, 3, 0, 0, 0, 1, 0, 0, 1);
    wr_line(3, 1, 0, 0, 0, 1, 0, 0, 1);
    run = 1'b1;
    tick(40);
    chk(hits[1] == 4 * (d_len[1] + 1), "R4 block repeated", hits[1], 4 * (d_len[1] + 1));
    chk(hits[3] == 0, "R8 jumped over line", hits[3], 0);
    chk(hits[2] == d_len[2] + 1, "R8 jump line played", hits[2], d_len[2] + 1);
    chk(done && !pat_valid, "R10 done after last line", int'({done, pat_valid}), 2);
    stop_run();
    chk(!done && !pat_valid, "R2 run low clears", int'({done, pat_valid}), 0);

    // R6 wait-for gate
    clear_prog();
    wr_line(0, 0, 0, 0, 1, 1, 0, 0, 1);
    run = 1'b1;
    tick(10);
    chk(!pat_valid, "R6 held while waiting", int'(pat_valid), 0);
    chk(sig_out, "R9 level during wait", int'(sig_out), 1);
    evt_in = 1'b1;
    tick(1);
    evt_in = 1'b0;
    chk(pat_valid && pat_addr == PA_W'(d_start[0]), "R6 first beat after event", int'(pat_addr), d_start[0]);
    tick(6);
    stop_run();

    // R7 jump-if, event low: falls through to line 1
    clear_prog();
    wr_line(0, 1, 1, 0, 0, 0, 1, 2, 0);
    wr_line(1, 2, 0, 0, 0, 0, 0, 0, 1);
    wr_line(2, 3, 0, 0, 0, 0, 0, 0, 1);
    run = 1'b1;
    tick(30);
    chk(hits[2] == d_len[2] + 1 && hits[3] == 0, "R7 no event goes next", hits[3], 0);
    chk(hits[1] == 2 * (d_len[1] + 1), "R4 two passes", hits[1], 2 * (d_len[1] + 1));
    stop_run();
    // event held high: goes to target
    evt_in = 1'b1;
    run = 1'b1;
    tick(30);
    chk(hits[3] == d_len[3] + 1 && hits[2] == 0, "R7 event goes to target", hits[2], 0);
    stop_run();

    // R5 infinite line leaves only on a jump
    clear_prog();
    wr_line(0, 1, 0, 1, 0, 1, 1, 1, 0);
    wr_line(1, 2, 0, 0, 0, 0, 0, 0, 1);
    run = 1'b1;
    tick(50);
    chk(pat_valid && !done && hits[1] > 5 * (d_len[1] + 1), "R5 still looping", hits[1], 5 * (d_len[1] + 1));
    evt_in = 1'b1;
    tick(20);
    chk(done && hits[2] == d_len[2] + 1, "R5 left on jump", hits[2], d_len[2] + 1);
    stop_run();

    // R11 step mode ignores evt_in
    clear_prog();
    wr_line(0, 0, 0, 0, 1, 0, 0, 0, 1);
    step_mode = 1'b1;
    evt_in = 1'b1;
    run = 1'b1;
    tick(10);
    chk(!pat_valid, "R11 evt_in ignored in step mode", int'(pat_valid), 0);
    step_sat = 1'b1;
    tick(1);
    step_sat = 1'b0;
    chk(pat_valid, "R11 satisfy strobe releases", int'(pat_valid), 1);
    stop_run();
    step_mode = 1'b0;

    // R12 rewritten descriptor, R1 block field decode
    wr_desc(5, 12'h123, 0);
    clear_prog();
    wr_line(0, 5, 0, 0, 0, 0, 0, 0, 1);
    run = 1'b1;
    tick(1);
    chk(pat_valid && pat_addr == 12'h123, "R12 R1 new descriptor used", int'(pat_addr), 12'h123);
    tick(3);
    stop_run();

    // R3 back-pressure and mixed behaviour: random programs
    for (int p = 0; p < 25; p++) begin
      for (int k = 0; k < BLK_DEPTH; k++) wr_desc(k, $urandom % 4096, $urandom % 6);
      for (int i = 0; i < SEQ_DEPTH; i++)
        wr_line(i, $urandom % BLK_DEPTH, $urandom % 3, ($urandom % 8) == 0, ($urandom % 4) == 0,
                $urandom % 2, $urandom % 4, $urandom % SEQ_DEPTH, ($urandom % 6) == 0);
      step_mode = ($urandom % 3) == 0;
      rnd_ready = 1; rnd_evt = 1; rnd_step = 1;
      run = 1'b1;
      tick(400);
      rnd_ready = 0; rnd_evt = 0; rnd_step = 0;
      stop_run();
      step_mode = 1'b0;
    end

    $display("  == %0d vectors applied, %0d miscompares ==", nvec, nfail);
    $finish;
  end

endmodule